// File: doc/BRIEF.md
# SATA host controller register file

This block is the software-visible register space of a two-port SATA host controller. A processor reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and a read-data return. The block holds the controller-wide registers and one register set per port. A port's register set holds these registers:

- command list base and received-FIS base, each as a low and a high word
- interrupt status and interrupt enable
- port command
- taskfile and device signature
- four link registers: status, control, error and active
- command issue

The command engine next to the block reports events by setting bits in a port's interrupt status. Software acknowledges them by writing ones. Every port whose enabled status is nonzero sets its bit in a sticky controller-wide pending bitmap, and a single level interrupt line follows that bitmap. When software starts a port or issues commands to a running port, the block emits a one-cycle start pulse for that port, which wakes the command engine.

Top module: `sata_host_regs`

## Requirements
- R1: After reset these reads return fixed values. Offset 0x00 returns 0x00001F02 (port count in bits 4:0, slot count minus one in bits 12:8). Offset 0x04 returns 0x80000000, offset 0x0C returns 0x00000001 and offset 0x10 returns 0x00010100. Every port register reads 0, irq_o is low and kick_o is 0.
- R2: Only addr_i[11:0] is decoded, and reads ignore addr_i[1:0]. Controller registers sit below 0x20. Port p occupies 0x100+p*0x80 to 0x17F+p*0x80, with the register offset in addr_i[6:0]. Every other address reads 0, and so do port offsets 0x1C and 0x3C to 0x7F.
- R3: These port registers store and return all 32 written bits: 0x00 and 0x04 (command list base), 0x08 and 0x0C (FIS base), 0x14 (interrupt enable), 0x20 (taskfile), 0x24 (signature), 0x2C (link control), 0x30 (link error), 0x34 (link active) and 0x38 (command issue).
- R4: Port interrupt status at offset 0x10 gains every bit asserted on that port's slice of stat_set_i at a clock edge. A write to it clears the bits written as one. When a bit is set and cleared at the same edge, the clear wins.
- R5: The controller pending bitmap at offset 0x08 has bit p set at the clock edge after port p shows a nonzero (status AND enable). A write of ones to it clears those bits, except for any bit whose port is still pending at that edge, which stays set.
- R6: irq_o is high exactly when the controller pending bitmap is nonzero.
- R7: A write to port offset 0x18 stores only the bits in mask 0x0100C01F. All other bits read back as 0.
- R8: Port offset 0x28 (link status) ignores writes. On port 0 it reads 3 while drive_present_i is high and 0 otherwise. On every other port it reads 0.
- R9: A write with addr_i[1:0] not zero changes no register and produces no start pulse.
- R10: kick_o[p] is high for the one cycle after one of two writes to port p. The first is a write to offset 0x38 made while bit 0 of that port's command register is already set. The second is a write to offset 0x18 whose data bit 0 is one. Any other write leaves kick_o low.
- R11: Writes to controller offsets 0x00, 0x04, 0x0C and 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| drive_present_i | input | 1 | A drive is attached to port 0 |
| stat_set_i | input | 64 | Interrupt status set bits, 32 per port, port 0 in the low word |
| irq_o | output | 1 | Level interrupt |
| kick_o | output | 2 | One-cycle start pulse per port |

## Verification
A corrupted status or enable flop in a port shows up one cycle later as a wrong pending bit on irq_o, and it can be read back at offset 0x10 or 0x14 at once. A lost or extra pending bit shows on irq_o the cycle after the port state changes. A wrong command register value shows first as a missing or spurious start pulse on the next command-issue write. Random accesses across every decoded and undecoded offset are compared each cycle against a reference model, and directed cases cover the same-edge set and clear, a pending bit that survives its own clear, and writes that must be ignored.

// File: rtl/shr_pkg.sv
package shr_pkg;
  // port register word indices (byte offset / 4)
  localparam logic [4:0] W_CLB_LO = 5'd0;
  localparam logic [4:0] W_CLB_HI = 5'd1;
  localparam logic [4:0] W_FB_LO  = 5'd2;
  localparam logic [4:0] W_FB_HI  = 5'd3;
  localparam logic [4:0] W_IS     = 5'd4;
  localparam logic [4:0] W_IE     = 5'd5;
  localparam logic [4:0] W_CMD    = 5'd6;
  localparam logic [4:0] W_TFD    = 5'd8;
  localparam logic [4:0] W_SIG    = 5'd9;
  localparam logic [4:0] W_LSTAT  = 5'd10;
  localparam logic [4:0] W_LCTL   = 5'd11;
  localparam logic [4:0] W_LERR   = 5'd12;
  localparam logic [4:0] W_LACT   = 5'd13;
  localparam logic [4:0] W_CI     = 5'd14;
  localparam int          N_WORDS  = 16;
  // words held as plain 32-bit storage
  localparam logic [15:0] STORE_MAP = 16'h7B2F;
  localparam logic [31:0] CMD_KEEP  = 32'h0100_C01F;
  localparam logic [11:0] G_IS_ADDR = 12'h008;
  localparam int          PORT_BASE = 256;
  localparam int          PORT_SPAN_LOG = 7;
endpackage

// File: rtl/shr_port.sv
module shr_port
  import shr_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [4:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] set_i,
  input  logic        drive_i,
  output logic [31:0] rdata_o,
  output logic        pend_o,
  output logic        kick_o
);
  logic [N_WORDS-1:0][31:0] word;
  logic [31:0] is_q, cmd_q, is_clr;
  logic        kick_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    if (STORE_MAP[w]) begin : g_flop
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_i && off_i == 5'(w)) q <= wdata_i;
      end
      assign word[w] = q;
    end else begin : g_zero
      assign word[w] = '0;
    end
  end

  assign is_clr = (wr_i && off_i == W_IS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_q   <= '0;
      cmd_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      is_q   <= (is_q | set_i) & ~is_clr;
      if (wr_i && off_i == W_CMD) cmd_q <= wdata_i & CMD_KEEP;
      kick_q <= wr_i && ((off_i == W_CI && cmd_q[0]) || (off_i == W_CMD && wdata_i[0]));
    end
  end

  always_comb begin
    unique case (off_i)
      W_IS:    rdata_o = is_q;
      W_CMD:   rdata_o = cmd_q;
      W_LSTAT: rdata_o = (IDX == 0 && drive_i) ? 32'd3 : 32'd0;
      default: rdata_o = off_i[4] ? 32'd0 : word[off_i[3:0]];
    endcase
  end

  assign pend_o = |(is_q & word[W_IE]);
  assign kick_o = kick_q;

  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && off_i == W_IS |=> (is_q & $past(wdata_i)) == 32'd0);
  a_r4_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != 32'd0 && !(wr_i && off_i == W_IS) |=> (is_q & $past(set_i)) == $past(set_i));
  a_r7_cmd_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && off_i == W_CMD |=> cmd_q == ($past(wdata_i) & CMD_KEEP));
  a_r10_kick_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> $past(wr_i));
  a_r10_kick_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o && $past(off_i == W_CI) |-> $past(cmd_q[0]));
endmodule

// File: rtl/shr_irq.sv
module shr_irq #(
  parameter int NPORT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] pend_i,
  input  logic [NPORT-1:0] clr_i,
  output logic [NPORT-1:0] gis_o,
  output logic             irq_o
);
  logic [NPORT-1:0] gis_q;

  // pending ports re-assert over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gis_q <= '0;
    else         gis_q <= (gis_q & ~clr_i) | pend_i;
  end

  assign gis_o = gis_q;
  assign irq_o = |gis_q;

  a_r5_pend_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i != '0 |=> (gis_q & $past(pend_i)) == $past(pend_i));
  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~pend_i) != '0 |=> (gis_q & $past(clr_i & ~pend_i)) == '0);
  a_r6_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pend_i != '0));
endmodule

// File: rtl/sata_host_regs.sv
module sata_host_regs
  import shr_pkg::*;
#(
  parameter int          NPORT   = 2,
  parameter int          NSLOT   = 32,
  parameter logic [31:0] PI_MAP  = 32'h1,
  parameter logic [31:0] VERSION = 32'h0001_0100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        addr_i,
  input  logic               wr_en_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               drive_present_i,
  input  logic [NPORT*32-1:0] stat_set_i,
  output logic               irq_o,
  output logic [NPORT-1:0]   kick_o
);
  localparam int          PIDX_W   = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int          PORT_END = PORT_BASE + (NPORT << PORT_SPAN_LOG);
  localparam logic [31:0] CAP_VAL  = 32'(NPORT) | (32'(NSLOT - 1) << 8);
  localparam logic [31:0] GHC_VAL  = 32'h8000_0000;

  logic              wr_ok, in_port;
  logic [PIDX_W-1:0] port_idx;
  logic [NPORT-1:0]  pend, gis, g_clr;
  logic [31:0]       port_rd [NPORT];

  assign wr_ok    = wr_en_i && addr_i[1:0] == 2'b00;
  assign in_port  = 32'(addr_i) >= 32'(PORT_BASE) && 32'(addr_i) < 32'(PORT_END);
  assign port_idx = PIDX_W'((addr_i - 12'(PORT_BASE)) >> PORT_SPAN_LOG);
  assign g_clr    = (wr_ok && addr_i == G_IS_ADDR) ? wdata_i[NPORT-1:0] : '0;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    shr_port #(.IDX(p)) i_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_ok && in_port && port_idx == PIDX_W'(p)),
      .off_i   (addr_i[6:2]),
      .wdata_i (wdata_i),
      .set_i   (stat_set_i[p*32 +: 32]),
      .drive_i (drive_present_i),
      .rdata_o (port_rd[p]),
      .pend_o  (pend[p]),
      .kick_o  (kick_o[p])
    );
  end

  shr_irq #(.NPORT(NPORT)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .clr_i  (g_clr),
    .gis_o  (gis),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i < 12'h020) begin
      unique case (addr_i[4:2])
        3'd0:    rdata_o = CAP_VAL;
        3'd1:    rdata_o = GHC_VAL;
        3'd2:    rdata_o = 32'(gis);
        3'd3:    rdata_o = PI_MAP;
        3'd4:    rdata_o = VERSION;
        default: rdata_o = '0;
      endcase
    end else if (in_port) begin
      rdata_o = port_rd[port_idx];
    end
  end

  a_r9_misaligned_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i[1:0] != 2'b00 |=> kick_o == '0);
  a_r6_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(g_clr != '0));
endmodule

// File: tb/test_sata_host_regs.sv
module test_sata_host_regs;
  localparam int NP = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     addr = '0;
  logic            wr_en = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            drive = 1'b0;
  logic [NP*32-1:0] sset = '0;
  logic            irq;
  logic [NP-1:0]   kick;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model
  logic [31:0] m_word [NP][16];
  logic [31:0] m_is [NP];
  logic [31:0] m_cmd [NP];
  logic [NP-1:0] m_gis, m_kick;

  always #4 clk = ~clk;

  sata_host_regs i_sata_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .drive_present_i(drive), .stat_set_i(sset), .irq_o(irq), .kick_o(kick)
  );

  function automatic bit plain_word(int w);
    return w inside {0, 1, 2, 3, 5, 8, 9, 11, 12, 13, 14};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        for (int w = 0; w < 16; w++) m_word[p][w] = '0;
        m_is[p] = '0; m_cmd[p] = '0;
      end
      m_gis = '0; m_kick = '0;
    end else begin
      logic [NP-1:0] pend;
      logic [NP-1:0] gclr;
      bit ok;
      for (int p = 0; p < NP; p++) pend[p] = |(m_is[p] & m_word[p][5]);
      ok = wr_en && addr[1:0] == 2'b00;
      gclr = (ok && addr == 12'h008) ? wdata[NP-1:0] : '0;
      m_gis = (m_gis & ~gclr) | pend;
      m_kick = '0;
      for (int p = 0; p < NP; p++) begin
        bit hit;
        int w;
        logic [31:0] clr;
        hit = ok && addr >= 12'h100 && addr < 12'h200 && int'((addr - 12'h100) >> 7) == p;
        w = int'(addr[6:2]);
        clr = (hit && w == 4) ? wdata : '0;
        if (hit && ((w == 14 && m_cmd[p][0]) || (w == 6 && wdata[0]))) m_kick[p] = 1'b1;
        m_is[p] = (m_is[p] | sset[p*32 +: 32]) & ~clr;
        if (hit && w == 6) m_cmd[p] = wdata & 32'h0100_C01F;
        if (hit && w < 16 && plain_word(w)) m_word[p][w] = wdata;
      end
    end
  end

  function automatic logic [31:0] exp_read(logic [11:0] a);
    int p, w;
    if (a < 12'h020) begin
      case (a[4:2])
        3'd0: return 32'h0000_1F02;
        3'd1: return 32'h8000_0000;
        3'd2: return 32'(m_gis);
        3'd3: return 32'h1;
        3'd4: return 32'h0001_0100;
        default: return 32'h0;
      endcase
    end
    if (a < 12'h100 || a >= 12'h200) return 32'h0;
    p = int'((a - 12'h100) >> 7);
    w = int'(a[6:2]);
    if (w == 4) return m_is[p];
    if (w == 6) return m_cmd[p];
    if (w == 10) return (p == 0 && drive) ? 32'd3 : 32'd0;
    if (w < 16 && plain_word(w)) return m_word[p][w];
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; afterwards kick and irq are compared against the model
  task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NP*32-1:0] s, input string req);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; sset = s;
    @(negedge clk);
    wr_en = 1'b0; sset = '0;
    #1;
    check({req, " kick"}, 32'(kick), 32'(m_kick));
    check({req, " irq"}, 32'(irq), 32'(m_gis != '0));
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check($sformatf("%s rd %h", req, a), rdata, exp_read(a));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    tick(1'b1, a, d, '0, req);
  endtask

  function automatic logic [11:0] rand_addr();
    int k;
    k = int'($urandom_range(0, 9));
    if (k == 0) return 12'(4 * $urandom_range(0, 7));
    if (k == 8) return 12'($urandom);
    if (k == 9) return 12'(12'h100 + 4 * $urandom_range(0, 63) + $urandom_range(1, 3));
    return 12'(12'h100 + 12'h80 * $urandom_range(0, 1) + 4 * $urandom_range(0, 16));
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL timeout all-requirements actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values, checked against constants
    addr = 12'h000; #1 check("R1 cap", rdata, 32'h0000_1F02);
    addr = 12'h004; #1 check("R1 ghc", rdata, 32'h8000_0000);
    addr = 12'h00C; #1 check("R1 pi", rdata, 32'h1);
    addr = 12'h010; #1 check("R1 version", rdata, 32'h0001_0100);
    addr = 12'h190; #1 check("R1 port1 is", rdata, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 kick", 32'(kick), 32'h0);

    // R3 storage, R2 holes
    wr(12'h100, 32'hDEAD_BEEF, "R3");
    rd(12'h100, "R3");
    wr(12'h1A0, 32'h1234_5678, "R3");
    rd(12'h1A0, "R3");
    wr(12'h11C, 32'hFFFF_FFFF, "R2");
    rd(12'h11C, "R2");
    rd(12'h103, "R2");
    rd(12'h0F0, "R2");
    rd(12'h204, "R2");

    // R7 command mask
    wr(12'h118, 32'hFFFF_FFFE, "R7");
    addr = 12'h118; #1 check("R7 cmd", rdata, 32'h0100_C01E);

    // R10 kicks: CI while start clear, cmd with start, CI while start set
    wr(12'h138, 32'h1, "R10 ci-no-start");
    check("R10 no kick", 32'(kick), 32'h0);
    wr(12'h198, 32'h1, "R10 start");
    check("R10 start kick", 32'(kick), 32'h2);
    wr(12'h1B8, 32'h3, "R10 ci");
    check("R10 ci kick", 32'(kick), 32'h2);

    // R9 misaligned write ignored
    wr(12'h1B9, 32'hFFFF_FFFF, "R9");
    rd(12'h1B8, "R9");
    wr(12'h119, 32'h1, "R9");
    check("R9 no kick", 32'(kick), 32'h0);

    // R11 read-only controller registers
    wr(12'h004, 32'h0, "R11");
    rd(12'h004, "R11");
    wr(12'h000, 32'h0, "R11");
    rd(12'h000, "R11");

    // R8 link status
    wr(12'h128, 32'hFF, "R8");
    rd(12'h128, "R8");
    drive = 1'b1;
    rd(12'h128, "R8");
    rd(12'h1A8, "R8");

    // R4 clear wins over set in the same edge
    tick(1'b1, 12'h110, 32'h0000_0005, 64'h0000_0000_0000_0007, "R4 same edge");
    addr = 12'h110; #1 check("R4 clear wins", rdata, 32'h2);

    // R5/R6 irq latency: enable then status
    wr(12'h114, 32'h2, "R5");
    check("R5 pend after enable", 32'(irq), 32'h0);
    tick(1'b0, 12'h0, 32'h0, '0, "R6");
    check("R6 irq up", 32'(irq), 32'h1);
    // global clear while port still pending: stays
    wr(12'h008, 32'h1, "R5 sticky");
    rd(12'h008, "R5");
    wr(12'h110, 32'h2, "R4 ack");
    wr(12'h008, 32'h1, "R5 clear");
    check("R6 irq down", 32'(irq), 32'h0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [NP*32-1:0] s;
      logic [31:0] d;
      logic [11:0] a;
      a = rand_addr();
      d = $urandom;
      if (a[6:0] == 7'h14) d = d & $urandom & $urandom;
      s = ($urandom_range(0, 3) == 0) ? {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom} : '0;
      if ($urandom_range(0, 40) == 0) drive = ~drive;
      tick($urandom_range(0, 3) != 0, a, d, s, "R2-random");
      rd(rand_addr(), "R3 R4 R5 R7 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule